// File: doc/BRIEF.md
# Four-Plane Pixel Serializer with Double-Buffered Plane Words

This block turns planar video memory into a stream of 4-bit pixel indices. A memory controller hands over 16-bit plane words one at a time. Each handover is marked by an active-low load strobe. The block collects four such words, one for each bitplane, in a front bank of holding registers. It then moves all four at once into a back bank of shift registers. The back bank emits one bit from every plane on each pixel clock, most significant bit first.

Everything runs on one pixel clock; the strobe is never used as a clock. The strobe passes through a two-stage synchronizer and an edge detector, so each falling edge stores exactly one word. The bank transfer happens on the same clock edge that shifts out the last bit of the previous word. As a result, the pixel stream has no idle or repeated pixel at the 16-pixel seams. If the front bank is not full when a seam is reached, the back bank is filled with zeros for that word and an underrun flag is raised.

Top module: `bitplane_shifter`

## Requirements
- R1: While `rst_n` is low at a rising edge, all registers and counters clear. After that edge `pixel` reads 0 and `underrun` reads 0.
- R2: `load_n` goes through a two-stage synchronizer. Each high-to-low transition stores exactly one word, however long `load_n` then stays low. The word is taken from `load_data` on the third rising edge at which `load_n` is sampled low, counting the first such sample.
- R3: Stored words go into plane registers 0, 1, 2, 3 in that order. The plane counter restarts at plane 0 after each bank transfer.
- R4: Once four words are held and no transfer has yet taken them, further load strobes are discarded. They overwrite no plane register.
- R5: A 16-pixel seam occurs on every 16th rising edge after reset release, the first one on the 16th edge.
- R6: At a seam where all four planes are held, the four words move together into the shift bank. For the 16 cycles that follow, with i = 0..15, `pixel` is {plane3[15-i], plane2[15-i], plane1[15-i], plane0[15-i]}. Bit 3 of `pixel` is plane 3, and each word is sent MSB first.
- R7: The first pixel of a newly transferred word appears in the cycle right after the last pixel of the previous word. No cycle is idle or repeated at the seam.
- R8: At a seam where fewer than four planes are held, the shift bank loads zeros, so `pixel` is 0 for the next 16 cycles. `underrun` is 1 for exactly those 16 cycles. Words already stored are kept, and filling continues at the next plane.
- R9: Between seams the shift bank moves every plane left by one bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Word strobe from the memory controller, active low, asynchronous |
| load_data | input | 16 | Plane word, held stable while being taken |
| pixel | output | 4 | Pixel index, one bit per plane |
| underrun | output | 1 | High for the 16 pixels blanked by a missed seam |

## Verification
The bench aims at strobes held low for many cycles. A design that acts on levels instead of edges would store one word into several planes. It also sends surplus strobes after the front bank is full; a wrong design would let them overwrite plane 3 or wrap around into plane 0. It compares every pixel on both sides of each seam, which exposes a one-cycle gap, a repeated pixel or a swapped plane order. Idle stretches and a reset in mid-frame test the zero fill, the underrun window and the kept partial loads.

// File: rtl/bps_pkg.sv
package bps_pkg;
  parameter int PLANES      = 4;
  parameter int WORD_W      = 16;
  parameter int SYNC_STAGES = 2;

  localparam int PCNT_W = $clog2(PLANES + 1);
  localparam int SCNT_W = $clog2(WORD_W);

  typedef struct packed {
    logic              boundary;   // last bit of current word leaves this cycle
    logic              transfer;   // front bank moves into shift bank
    logic [PLANES-1:0] planeWe;    // one-hot front register write
  } bps_strobe_t;
endpackage

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_n,
  output bps_strobe_t strobes,
  output logic        underrun
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;
  logic                   loadPulse;
  logic [PCNT_W-1:0]      planeCnt;
  logic [SCNT_W-1:0]      shiftCnt;
  logic                   bankFull;
  logic                   seam;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncChain <= '1;
      prevLevel <= 1'b1;
    end else begin
      if (SYNC_STAGES > 1)
        syncChain <= {syncChain[SYNC_STAGES-2:0], load_n};
      else
        syncChain <= load_n;
      prevLevel <= syncChain[SYNC_STAGES-1];
    end
  end

  assign loadPulse = prevLevel & ~syncChain[SYNC_STAGES-1];
  assign bankFull  = (planeCnt == PCNT_W'(PLANES));
  assign seam      = (shiftCnt == SCNT_W'(WORD_W - 1));

  assign strobes.boundary = seam;
  assign strobes.transfer = seam & bankFull;

  for (genvar p = 0; p < PLANES; p++) begin : g_sel
    assign strobes.planeWe[p] = loadPulse & ~bankFull & (planeCnt == PCNT_W'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftCnt <= '0;
      planeCnt <= '0;
      underrun <= 1'b0;
    end else begin
      shiftCnt <= seam ? '0 : shiftCnt + 1'b1;
      if (strobes.transfer)
        planeCnt <= '0;
      else if (loadPulse && !bankFull)
        planeCnt <= planeCnt + 1'b1;
      if (seam)
        underrun <= ~bankFull;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    loadPulse |=> !loadPulse); // R2
  AST_PLANE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.transfer |=> planeCnt == '0); // R3
  AST_PLANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    planeCnt <= PCNT_W'(PLANES)); // R4
  AST_SEAM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    seam |=> shiftCnt == '0); // R5
endmodule

// File: rtl/bps_datapath.sv
module bps_datapath
  import bps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] load_data,
  input  bps_strobe_t       strobes,
  output logic [PLANES-1:0] pixel
);
  logic [WORD_W-1:0] frontReg [PLANES];
  logic [WORD_W-1:0] shiftReg [PLANES];

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rst_n)
        frontReg[p] <= '0;
      else if (strobes.planeWe[p])
        frontReg[p] <= load_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        shiftReg[p] <= '0;
      else if (strobes.boundary)
        shiftReg[p] <= strobes.transfer ? frontReg[p] : '0;
      else
        shiftReg[p] <= {shiftReg[p][WORD_W-2:0], 1'b0};
    end

    assign pixel[p] = shiftReg[p][WORD_W-1];

    AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !strobes.planeWe[p] |=> $stable(frontReg[p])); // R4
    AST_BANK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.transfer |=> shiftReg[p] == $past(frontReg[p])); // R6
  end

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.boundary && !strobes.transfer) |=> pixel == '0); // R8
endmodule

// File: rtl/bitplane_shifter.sv
module bitplane_shifter
  import bps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [WORD_W-1:0] load_data,
  output logic [PLANES-1:0] pixel,
  output logic              underrun
);
  bps_strobe_t strobes;

  bps_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .strobes  (strobes),
    .underrun (underrun)
  );

  bps_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_data (load_data),
    .strobes   (strobes),
    .pixel     (pixel)
  );
endmodule

// File: tb/bitplane_shifter_tb.sv
`timescale 1ns/1ps
module bitplane_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic [15:0] load_data = '0;
  logic [3:0]  pixel;
  logic        underrun;

  int checks = 0;
  int fails  = 0;
  string curTag = "R1";

  // reference state
  logic [15:0] mPlane [4];
  logic [15:0] mShift [4];
  int          mCnt;
  logic        mUnd;
  int          edgeIdx;
  logic        lastDrv;
  int          capQ [$];

  always #2.5 clk = ~clk;

  bitplane_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_data(load_data),
    .pixel(pixel), .underrun(underrun)
  );

  function automatic logic [4:0] expOut();
    return {mUnd, mShift[3][15], mShift[2][15], mShift[1][15], mShift[0][15]};
  endfunction

  task automatic modelClear();
    for (int p = 0; p < 4; p++) begin mPlane[p] = '0; mShift[p] = '0; end
    mCnt = 0; mUnd = 1'b0; edgeIdx = 0; lastDrv = 1'b1; capQ.delete();
  endtask

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge=%0d {underrun,pixel} act=%b exp=%b", tag, edgeIdx, act, exp);
    end
  endtask

  // one clock: model the edge per R2..R9, then compare at the falling edge
  task automatic tick();
    bit pulse, full, seam;
    if (rst_n && load_n == 1'b0 && lastDrv == 1'b1) capQ.push_back(edgeIdx + 2); // R2 latency
    lastDrv = load_n;
    @(posedge clk);
    if (!rst_n) begin
      modelClear();
    end else begin
      pulse = (capQ.size() > 0 && capQ[0] == edgeIdx);
      if (pulse) void'(capQ.pop_front());
      full = (mCnt == 4);
      seam = ((edgeIdx % 16) == 15);           // R5
      if (seam) begin
        for (int p = 0; p < 4; p++) mShift[p] = full ? mPlane[p] : 16'h0; // R6 R8
        mUnd = !full;
      end else begin
        for (int p = 0; p < 4; p++) mShift[p] = {mShift[p][14:0], 1'b0}; // R9
      end
      if (pulse && !full) begin                // R3 R4
        mPlane[mCnt] = load_data;
        mCnt++;
      end
      if (seam && full) mCnt = 0;
      edgeIdx++;
    end
    @(negedge clk);
    check(curTag, {underrun, pixel}, expOut());
  endtask

  task automatic loadWord(logic [15:0] w, int lowCyc, int highCyc);
    load_n = 1'b0; load_data = w;
    repeat (lowCyc) tick();
    load_n = 1'b1;
    repeat (highCyc) tick();
  endtask

  task automatic doReset(int n);
    rst_n = 1'b0; load_n = 1'b1;
    repeat (n) tick();
    rst_n = 1'b1;
    curTag = "R1";
    check("R1", {underrun, pixel}, 5'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    modelClear();
    @(negedge clk);
    doReset(3);

    // R5: idle through the first seam, then R8 blank word
    curTag = "R5";
    repeat (16) tick();
    curTag = "R8";
    repeat (20) tick();

    // R3/R6: four distinct words, MSB-first plane order
    curTag = "R3";
    loadWord(16'h8001, 2, 1);
    loadWord(16'hC003, 2, 1);
    loadWord(16'hA5A5, 2, 1);
    loadWord(16'hF00F, 2, 1);
    curTag = "R6";
    repeat (30) tick();

    // R7: back-to-back sets, seams must be seamless
    curTag = "R7";
    for (int s = 0; s < 12; s++) begin
      for (int p = 0; p < 4; p++) loadWord(16'($urandom), 2, 1);
      repeat (4) tick();
    end

    // R2: long strobes, each counts once
    curTag = "R2";
    for (int p = 0; p < 4; p++) loadWord(16'h1111 * 16'(p + 1) ^ 16'h8421, 7, 2);
    repeat (40) tick();

    // R4: surplus strobes after four are held
    curTag = "R4";
    repeat (8) begin
      loadWord(16'($urandom), 2, 1);
    end
    repeat (40) tick();

    // R8: partial load then starvation, remaining planes later
    curTag = "R8";
    loadWord(16'hDEAD, 2, 1);
    loadWord(16'hBEEF, 2, 1);
    repeat (40) tick();
    loadWord(16'h0F0F, 2, 1);
    loadWord(16'h7E81, 2, 1);
    repeat (40) tick();

    // R9: random strobe spacing and data
    curTag = "R9";
    for (int k = 0; k < 300; k++)
      loadWord(16'($urandom), 2 + int'($urandom % 4), 1 + int'($urandom % 6));
    repeat (20) tick();

    // R1: reset mid-frame, then resume
    loadWord(16'h1234, 2, 1);
    doReset(2);
    repeat (15) tick();
    curTag = "R8";
    repeat (10) tick();
    curTag = "R6";
    for (int p = 0; p < 4; p++) loadWord(16'h3C5A + 16'(p), 3, 2);
    repeat (40) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule